// File: doc/BRIEF.md
# Basic Up-Counting Timer with Update Control

The block is a general-purpose up-counter driven by a programmable clock divider. Software programs it through a small write port and a combinational read port. The settings are a control word, a wrap limit, a divider ratio and a strobe that forces an update. The counter climbs from zero to the active wrap limit. On the divided tick where the count equals the limit, it returns to zero and raises an update event.

An update event copies the buffered settings into their working registers and sets a sticky event flag. Through per-output enables and a source filter, it also emits a one-cycle interrupt pulse and a one-cycle DMA request pulse. The same update can also come from a software strobe or from a one-cycle pulse on a slave input. In single-shot mode the timer stops itself at the first update. Software can suppress update events altogether.

Top module: `basic_uptimer`

## Requirements
- R1: After reset, the count, the control word (address 0), the output enables (address 1), the flag (address 2) and the divider ratio (address 4) are all 0. The wrap limit (address 5) is all ones, and `irq_o` and `dma_o` are low.
- R2: The count advances only on a divided tick while the run bit (control bit 0) is 1. While the run bit is 0, the count holds its value.
- R3: When the count equals the active wrap limit on a tick, it goes to 0 on that same tick, and this overflow raises an update event.
- R4: A tick occurs once every (active divider ratio + 1) clocks. A value written to address 4 becomes active only at an update event.
- R5: With control bit 7 at 0, a write to address 5 changes the active wrap limit at once. With bit 7 at 1, the written value waits and becomes active at the next update event.
- R6: With control bit 3 at 1, an update event clears the run bit, so the count stops.
- R7: With control bit 1 at 1, no update event occurs. The flag, the buffered values and both request outputs are untouched, while the count still wraps or clears.
- R8: Writing a word with bit 0 set to address 3 clears the count and the divider counter and raises an update event.
- R9: With control bit 2 at 0, any update source produces a request. With bit 2 at 1, only a counter overflow does.
- R10: Every update event sets the flag (address 2 bit 0). Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R11: `irq_o` and `dma_o` pulse high for one cycle on the clock after a requesting update. They are gated by enable bits 0 and 1 at address 1.
- R12: A one-cycle pulse on `slave_upd_i` acts like the software strobe: it clears the counters, raises an update, and is subject to the filter of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | 3 | Register select for write and read |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data of the register at `addr_i` (address 6 gives the count) |
| slave_upd_i | input | 1 | One-cycle external update pulse |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Interrupt pulse |
| dma_o | output | 1 | DMA request pulse |

## Verification
The assertions assume that `slave_upd_i` is a single-cycle pulse. They also assume that software never writes the control word in the same cycle as an update event, because the single-shot stop check relies on that. The directed stimulus applies each write as a lone one-cycle strobe. It issues the strobes and slave pulses only while the control word stays unwritten, and it reprograms the wrap limit only while the timer is stopped or buffering is on.

// File: rtl/basic_tmr_pkg.sv
package basic_tmr_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ENA   = 3'd1,
    SEL_FLAG  = 3'd2,
    SEL_FORCE = 3'd3,
    SEL_DIV   = 3'd4,
    SEL_LIMIT = 3'd5,
    SEL_COUNT = 3'd6
  } tmr_sel_e;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_NOUPD = 1;
  localparam int unsigned BIT_OVONL = 2;
  localparam int unsigned BIT_SHOT  = 3;
  localparam int unsigned BIT_BUFL  = 7;

  typedef struct packed {
    logic buf_limit;
    logic shot;
    logic ovf_only;
    logic no_upd;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/basic_tmr_div.sv
module basic_tmr_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign tick_o = run_i && (cnt_q == ratio_i);
  assign cnt_en = clr_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: divider frozen while stopped and not cleared
  a_r2_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/basic_tmr_core.sv
module basic_tmr_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign ovf_o   = tick_i && (cnt_q == limit_i);
  assign count_o = cnt_q;
  assign cnt_en  = clr_i || tick_i;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr_i || ovf_o) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/basic_tmr_shadow.sv
module basic_tmr_shadow #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         buf_i,
  input  logic         upd_i,
  output logic [W-1:0] pre_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pre_q, act_q, act_d;
  logic         act_en;

  always_comb begin
    act_en = 1'b0;
    act_d  = act_q;
    if (wr_i && !buf_i) begin
      act_en = 1'b1;
      act_d  = wdata_i;
    end else if (upd_i && buf_i) begin
      act_en = 1'b1;
      act_d  = pre_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      if (wr_i)   pre_q <= wdata_i;
      if (act_en) act_q <= act_d;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;

  // R5/R4: buffered value only moves on an update event
  a_r5_buffered_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_i && !upd_i) |=> $stable(act_q));
endmodule

// File: rtl/basic_uptimer.sv
module basic_uptimer
  import basic_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             slave_upd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             dma_o
);
  localparam logic [CNT_W-1:0] LIMIT_RST = {CNT_W{1'b1}};

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [1:0]       ena_q;
  logic             flag_q, flag_d;
  logic             irq_q, dma_q;
  logic             wr_ctrl, wr_ena, wr_flag, wr_force, wr_div, wr_limit;
  logic             force_upd, clr_cnt, upd_evt, req, ovf, tick;
  logic [CNT_W-1:0] div_pre, div_act, lim_pre, lim_act, cnt;

  assign wr_ctrl  = wr_en_i && (addr_i == SEL_CTRL);
  assign wr_ena   = wr_en_i && (addr_i == SEL_ENA);
  assign wr_flag  = wr_en_i && (addr_i == SEL_FLAG);
  assign wr_force = wr_en_i && (addr_i == SEL_FORCE);
  assign wr_div   = wr_en_i && (addr_i == SEL_DIV);
  assign wr_limit = wr_en_i && (addr_i == SEL_LIMIT);

  assign force_upd = wr_force && wdata_i[0];
  assign clr_cnt   = force_upd || slave_upd_i;
  assign upd_evt   = !ctrl_q.no_upd && (ovf || clr_cnt);
  assign req       = upd_evt && (!ctrl_q.ovf_only || ovf);

  basic_tmr_div #(.W(CNT_W)) div_i (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .clr_i(clr_cnt),
    .ratio_i(div_act), .tick_o(tick)
  );

  basic_tmr_core #(.W(CNT_W)) core_i (
    .clk_i, .rst_ni, .tick_i(tick), .clr_i(clr_cnt),
    .limit_i(lim_act), .count_o(cnt), .ovf_o(ovf)
  );

  basic_tmr_shadow #(.W(CNT_W), .RST_VAL('0)) div_sh_i (
    .clk_i, .rst_ni, .wr_i(wr_div), .wdata_i, .buf_i(1'b1),
    .upd_i(upd_evt), .pre_o(div_pre), .act_o(div_act)
  );

  basic_tmr_shadow #(.W(CNT_W), .RST_VAL(LIMIT_RST)) lim_sh_i (
    .clk_i, .rst_ni, .wr_i(wr_limit), .wdata_i, .buf_i(ctrl_q.buf_limit),
    .upd_i(upd_evt), .pre_o(lim_pre), .act_o(lim_act)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run       = wdata_i[BIT_RUN];
      ctrl_d.no_upd    = wdata_i[BIT_NOUPD];
      ctrl_d.ovf_only  = wdata_i[BIT_OVONL];
      ctrl_d.shot      = wdata_i[BIT_SHOT];
      ctrl_d.buf_limit = wdata_i[BIT_BUFL];
    end
    if (upd_evt && ctrl_q.shot) ctrl_d.run = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (upd_evt)                     flag_d = 1'b1;
    else if (wr_flag && !wdata_i[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ena_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq_q  <= req && ena_q[0];
      dma_q  <= req && ena_q[1];
      if (wr_ena) ena_q <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_CTRL: begin
        rdata_o[BIT_RUN]   = ctrl_q.run;
        rdata_o[BIT_NOUPD] = ctrl_q.no_upd;
        rdata_o[BIT_OVONL] = ctrl_q.ovf_only;
        rdata_o[BIT_SHOT]  = ctrl_q.shot;
        rdata_o[BIT_BUFL]  = ctrl_q.buf_limit;
      end
      SEL_ENA:   rdata_o[1:0] = ena_q;
      SEL_FLAG:  rdata_o[0]   = flag_q;
      SEL_DIV:   rdata_o      = div_pre;
      SEL_LIMIT: rdata_o      = lim_pre;
      SEL_COUNT: rdata_o      = cnt;
      default:   rdata_o      = '0;
    endcase
  end

  assign count_o = cnt;
  assign irq_o   = irq_q;
  assign dma_o   = dma_q;

  a_r6_shot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_evt && ctrl_q.shot && !wr_ctrl) |=> !ctrl_q.run);
  a_r7_no_flag_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> !$past(ctrl_q.no_upd));
  a_r10_flag_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(wr_flag && !wdata_i[0]));
  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ena_q[0]));
  a_r9_filter_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ovf_only && !ovf) |=> (!irq_o && !dma_o));
endmodule

// File: tb/basic_uptimer_tb.sv
module basic_uptimer_tb_top;
  localparam int  CLK_P = 10;
  localparam int  W     = 16;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         wr_en;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic         slave_upd;
  logic [W-1:0] count;
  logic         irq, dma;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  basic_uptimer #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .slave_upd_i(slave_upd),
    .count_o(count), .irq_o(irq), .dma_o(dma)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    addr  = a;
    wdata = W'(d);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_slave();
    slave_upd = 1'b1;
    @(negedge clk);
    slave_upd = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; slave_upd = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'(dma), 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, v); chk("R1 flag", v, 0);
    rd(3'd1, v); chk("R1 enables", v, 0);
    rd(3'd4, v); chk("R1 divider", v, 0);
    rd(3'd5, v); chk("R1 limit", v, 65535);
  endtask

  task automatic t_count_wrap();
    int v;
    do_reset();
    wr(3'd1, 3);
    wr(3'd5, 4);
    wr(3'd0, 1);
    chk("R2 start", int'(count), 0);
    cyc(4);
    chk("R2 count4", int'(count), 4);
    chk("R11 no early irq", int'(irq), 0);
    cyc(1);
    chk("R3 wrap", int'(count), 0);
    chk("R11 irq pulse", int'(irq), 1);
    chk("R11 dma pulse", int'(dma), 1);
    rd(3'd2, v); chk("R10 flag set", v, 1);
    cyc(1);
    chk("R11 irq one cycle", int'(irq), 0);
    chk("R2 after wrap", int'(count), 1);
    wr(3'd0, 0);
    cyc(3);
    chk("R2 frozen", int'(count), 2);
    rd(3'd6, v); chk("R2 count read", v, 2);
    wr(3'd2, 1);
    rd(3'd2, v); chk("R10 write1 keeps", v, 1);
    wr(3'd2, 0);
    rd(3'd2, v); chk("R10 write0 clears", v, 0);
  endtask

  task automatic t_divider();
    do_reset();
    wr(3'd4, 2);
    wr(3'd5, 9);
    wr(3'd0, 1);
    cyc(2);
    chk("R4 divider not yet active", int'(count), 2);
    wr(3'd3, 1);
    chk("R8 strobe clears", int'(count), 0);
    cyc(2);
    chk("R4 no tick before ratio", int'(count), 0);
    cyc(1);
    chk("R4 first tick", int'(count), 1);
    cyc(3);
    chk("R4 second tick", int'(count), 2);
  endtask

  task automatic t_filter();
    int v;
    do_reset();
    wr(3'd1, 1);
    wr(3'd0, 4);
    wr(3'd3, 1);
    chk("R9 strobe filtered", int'(irq), 0);
    rd(3'd2, v); chk("R10 flag on filtered", v, 1);
    pulse_slave();
    chk("R12 slave filtered", int'(irq), 0);
    wr(3'd0, 0);
    wr(3'd3, 1);
    chk("R9 strobe passes", int'(irq), 1);
    cyc(1);
    pulse_slave();
    chk("R12 slave passes", int'(irq), 1);
    wr(3'd5, 1);
    wr(3'd0, 5);
    cyc(1);
    chk("R9 pre-ovf count", int'(count), 1);
    cyc(1);
    chk("R9 overflow passes", int'(irq), 1);
    wr(3'd0, 0);
    cyc(2);
    wr(3'd0, 1);
    cyc(1);
    pulse_slave();
    chk("R12 slave clears count", int'(count), 0);
  endtask

  task automatic t_noupd();
    int v;
    do_reset();
    wr(3'd5, 3);
    wr(3'd1, 3);
    wr(3'd0, 3);
    cyc(3);
    chk("R7 count3", int'(count), 3);
    cyc(1);
    chk("R7 still wraps", int'(count), 0);
    chk("R7 no irq", int'(irq), 0);
    rd(3'd2, v); chk("R7 no flag", v, 0);
    wr(3'd4, 5);
    cyc(1);
    wr(3'd3, 1);
    chk("R7 strobe clears count", int'(count), 0);
    chk("R7 strobe no irq", int'(irq), 0);
    cyc(2);
    chk("R7 divider not loaded", int'(count), 2);
  endtask

  task automatic t_limit_modes();
    do_reset();
    wr(3'd5, 1);
    wr(3'd0, 1);
    cyc(1);
    chk("R5 immediate c1", int'(count), 1);
    cyc(1);
    chk("R5 immediate wrap", int'(count), 0);
    do_reset();
    wr(3'd5, 2);
    wr(3'd0, 128);
    wr(3'd5, 6);
    wr(3'd0, 129);
    cyc(2);
    chk("R5 old limit used", int'(count), 2);
    cyc(1);
    chk("R5 wrap at old", int'(count), 0);
    cyc(6);
    chk("R5 new limit c6", int'(count), 6);
    cyc(1);
    chk("R5 wrap at new", int'(count), 0);
  endtask

  task automatic t_one_shot();
    int v;
    do_reset();
    wr(3'd5, 2);
    wr(3'd1, 1);
    wr(3'd0, 9);
    cyc(2);
    chk("R6 c2", int'(count), 2);
    cyc(1);
    chk("R6 wrap", int'(count), 0);
    chk("R6 irq", int'(irq), 1);
    rd(3'd0, v); chk("R6 run cleared", v, 8);
    cyc(3);
    chk("R6 stays stopped", int'(count), 0);
  endtask

  initial begin
    t_reset();
    t_count_wrap();
    t_divider();
    t_filter();
    t_noupd();
    t_limit_modes();
    t_one_shot();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule